// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a timer that sits on an 8-bit register bus. It keeps a 16-bit channel value, reached as two byte-wide registers, and works in one of two roles. In capture mode, a chosen edge on an external input pin copies the free-running 16-bit counter into the channel value. In compare mode, software loads the value. When the counter reaches that value, the block raises a one-cycle event and applies a pin action.

The free-running counter enters as a port, and the block never changes it. Software reaches the value one byte at a time, so the block interlocks the two byte accesses. After a high-byte read in capture mode, the halves stay from the same capture until the low byte is read. After a high-byte write in compare mode, no match is taken on a half-written value.

Top module: `tmr_chan`

## Requirements
- R1: Bus address 0 reads channel bits 15..8 and address 1 reads bits 7..0 on `bus_rdata`, combinationally from `bus_addr`. Any other address reads 0.
- R2: A write strobe at address 0 or 1 stores `bus_wdata` into that half of the channel value in either mode. The other half keeps its value.
- R3: `mode_sel` = 00 selects capture mode. Any other value selects compare mode.
- R4: In capture mode, a qualifying edge on `cap_pin` stores `cnt_in` into the channel value. The edge selector `edge_sel` decodes as 00 none, 01 rising, 10 falling and 11 both. The pin passes through two synchronising flops and an edge register, so the store happens on the third rising clock edge after the pin changes. `cap_evt` is high for that one cycle.
- R5: In capture mode, a read of address 0 locks captures. A capture edge that arrives while the lock is set is discarded, not kept for later. The lock clears with the clock edge on which a read of address 1 completes.
- R6: In compare mode, when `cnt_in` equals the channel value and compares are unlocked, `cmp_evt` goes high for exactly one cycle, starting after the next clock edge. A counter that stays equal gives no further pulse.
- R7: In compare mode, a write to address 0 locks compares, and a write to address 1 releases the lock. While the lock is set, no compare event occurs.
- R8: `cmp_pin` resets to 0 and changes only on a compare event. The action on each event depends on the mode: 01 toggles the pin, 10 drives it to 0 and 11 drives it to 1.
- R9: Capture mode produces no compare events. Compare mode ignores pin edges, so the channel value does not change.
- R10: When a capture and a bus write of either byte fall on the same clock edge, the capture wins and the channel value holds the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (2) | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BUS_W (8) | Write data |
| bus_rdata | output | BUS_W (8) | Read data |
| mode_sel | input | 2 | Capture / compare action select |
| edge_sel | input | 2 | Capture edge select |
| cnt_in | input | CNT_W (16) | Free-running counter |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_evt | output | 1 | One-cycle capture indication |
| cmp_evt | output | 1 | One-cycle compare event |
| cmp_pin | output | 1 | Compare pin output |

## Verification
The bench builds the block with its defaults: a 16-bit counter, an 8-bit bus, a 2-bit address and two synchroniser stages. The 16-bit counter gives exactly two byte lanes, so both lock paths are exercised. The 2-bit address leaves addresses 2 and 3 unmapped, which reaches the read-as-zero path. The two synchroniser stages fix the capture latency at three clocks, which the bench uses to place a bus write on the same edge as a capture.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;

   typedef enum logic [1:0] {
      MODE_CAPTURE = 2'b00,
      MODE_TOGGLE  = 2'b01,
      MODE_CLEAR   = 2'b10,
      MODE_SET     = 2'b11
   } chan_mode_e;

   function automatic logic pin_next(input chan_mode_e m, input logic cur);
      case (m)
         MODE_TOGGLE: return ~cur;
         MODE_CLEAR:  return 1'b0;
         MODE_SET:    return 1'b1;
         default:     return cur;
      endcase
   endfunction

endpackage

// File: rtl/tmr_chan_insync.sv
module tmr_chan_insync
   import tmr_chan_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin_i,
   input  edge_sel_e edge_sel_i,
   output logic      hit_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_chan_insync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              rise, fall;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;
   assign fall = ~sync_q[STAGES-1] & prev_q;

   always_comb begin
      case (edge_sel_i)
         EDGE_RISE: hit_o = rise;
         EDGE_FALL: hit_o = fall;
         EDGE_ANY:  hit_o = rise | fall;
         default:   hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/tmr_chan_bytereg.sv
module tmr_chan_bytereg #(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output logic [BUS_W-1:0]  rdata_o,
   input  logic              cap_mode_i,
   input  logic              cap_hit_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [CNT_W-1:0]  val_o,
   output logic              cap_lock_o,
   output logic              cmp_lock_o,
   output logic              cap_evt_o
);

   localparam int NBYTES = CNT_W / BUS_W;
   localparam logic [ADDR_W-1:0] TOP_ADDR = '0;
   localparam logic [ADDR_W-1:0] BOT_ADDR = ADDR_W'(NBYTES - 1);

   logic [CNT_W-1:0] val_q;
   logic             cap_lock_q, cmp_lock_q, cap_evt_q;
   logic             rd_top, rd_bot, wr_top, wr_bot, cap_fire;
   logic [NBYTES-1:0] wr_sel;

   assign rd_top = rd_i && (addr_i == TOP_ADDR);
   assign rd_bot = rd_i && (addr_i == BOT_ADDR);
   assign wr_top = wr_i && (addr_i == TOP_ADDR);
   assign wr_bot = wr_i && (addr_i == BOT_ADDR);

   // a top-byte read on the same edge already closes the window
   assign cap_fire = cap_mode_i && cap_hit_i && !cap_lock_q && !rd_top;

   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_lane
         localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(NBYTES - 1 - i);
         assign wr_sel[i] = wr_i && (addr_i == LANE_ADDR);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         val_q[i*BUS_W +: BUS_W] <= '0;
            else if (cap_fire)  val_q[i*BUS_W +: BUS_W] <= cnt_i[i*BUS_W +: BUS_W];
            else if (wr_sel[i]) val_q[i*BUS_W +: BUS_W] <= wdata_i;
         end
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (addr_i == ADDR_W'(NBYTES - 1 - i)) rdata_o = val_q[i*BUS_W +: BUS_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_lock_q <= 1'b0;
         cmp_lock_q <= 1'b0;
         cap_evt_q  <= 1'b0;
      end else begin
         if (rd_bot)                   cap_lock_q <= 1'b0;
         else if (rd_top && cap_mode_i) cap_lock_q <= 1'b1;
         if (wr_bot)                   cmp_lock_q <= 1'b0;
         else if (wr_top && !cap_mode_i) cmp_lock_q <= 1'b1;
         cap_evt_q <= cap_fire;
      end
   end

   assign val_o      = val_q;
   assign cap_lock_o = cap_lock_q;
   assign cmp_lock_o = cmp_lock_q;
   assign cap_evt_o  = cap_evt_q;

endmodule

// File: rtl/tmr_chan_match.sv
module tmr_chan_match
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chan_mode_e       mode_i,
   input  logic             lock_i,
   input  logic [CNT_W-1:0] val_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             evt_o,
   output logic             pin_o
);

   logic match, match_q, evt_q, pin_q, start;

   assign match = (mode_i != MODE_CAPTURE) && !lock_i && (cnt_i == val_i);
   assign start = match && !match_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         evt_q   <= 1'b0;
         pin_q   <= 1'b0;
      end else begin
         match_q <= match;
         evt_q   <= start;
         if (start) pin_q <= pin_next(mode_i, pin_q);
      end
   end

   assign evt_o = evt_q;
   assign pin_o = pin_q;

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BUS_W       = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [1:0]        mode_sel,
   input  logic [1:0]        edge_sel,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic              cap_pin,
   output logic              cap_evt,
   output logic              cmp_evt,
   output logic              cmp_pin
);

   localparam int NBYTES = CNT_W / BUS_W;

   generate
      if (NBYTES * BUS_W != CNT_W || NBYTES < 2) begin : g_bad_width
         $error("tmr_chan: CNT_W must be a multiple (>=2) of BUS_W");
      end
      if ((1 << ADDR_W) < NBYTES) begin : g_bad_addr
         $error("tmr_chan: ADDR_W too narrow for the byte lanes");
      end
   endgenerate

   chan_mode_e       mode;
   logic             cap_hit, cap_lock_w, cmp_lock_w;
   logic [CNT_W-1:0] val_w;

   assign mode = chan_mode_e'(mode_sel);

   tmr_chan_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (cap_pin),
      .edge_sel_i (edge_sel_e'(edge_sel)),
      .hit_o      (cap_hit)
   );

   tmr_chan_bytereg #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (bus_addr),
      .rd_i       (bus_rd),
      .wr_i       (bus_wr),
      .wdata_i    (bus_wdata),
      .rdata_o    (bus_rdata),
      .cap_mode_i (mode == MODE_CAPTURE),
      .cap_hit_i  (cap_hit),
      .cnt_i      (cnt_in),
      .val_o      (val_w),
      .cap_lock_o (cap_lock_w),
      .cmp_lock_o (cmp_lock_w),
      .cap_evt_o  (cap_evt)
   );

   tmr_chan_match #(.CNT_W(CNT_W)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode),
      .lock_i (cmp_lock_w),
      .val_i  (val_w),
      .cnt_i  (cnt_in),
      .evt_o  (cmp_evt),
      .pin_o  (cmp_pin)
   );

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
   parameter int ADDR_W = 2,
   parameter int BUS_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic [1:0]        mode_sel,
   input logic              cap_evt,
   input logic              cmp_evt,
   input logic              cmp_pin,
   input logic              cap_lock,
   input logic              cmp_lock
);

   // R9
   cap_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |-> $past(mode_sel) == 2'b00);

   // R9
   cmp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_evt |-> $past(mode_sel) != 2'b00);

   // R5
   cap_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |-> !$past(cap_lock));

   // R5
   cap_lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == '0 && mode_sel == 2'b00) |=> cap_lock);

   // R7
   cmp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_evt |-> !$past(cmp_lock));

   // R6
   cmp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_evt |=> !cmp_evt);

   // R8
   pin_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_pin != $past(cmp_pin)) |-> cmp_evt);

   // R1
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr > ADDR_W'(1)) |-> bus_rdata == '0);

endmodule

bind tmr_chan tmr_chan_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .mode_sel  (mode_sel),
   .cap_evt   (cap_evt),
   .cmp_evt   (cmp_evt),
   .cmp_pin   (cmp_pin),
   .cap_lock  (cap_lock_w),
   .cmp_lock  (cmp_lock_w)
);

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [1:0]  mode_sel = 2'b00, edge_sel = 2'b00;
   logic [15:0] cnt_in = '0;
   logic        cap_pin = 1'b0;
   logic        cap_evt, cmp_evt, cmp_pin;

   int checks = 0, errors = 0;
   int cap_seen = 0, cmp_seen = 0;
   bit done = 0;

   always #10 clk = ~clk;

   tmr_chan u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .mode_sel(mode_sel), .edge_sel(edge_sel), .cnt_in(cnt_in),
      .cap_pin(cap_pin), .cap_evt(cap_evt), .cmp_evt(cmp_evt), .cmp_pin(cmp_pin)
   );

   always @(negedge clk) if (rst_n) begin
      if (cap_evt) cap_seen++;
      if (cmp_evt) cmp_seen++;
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1 bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1 bus_rd = 1'b0;
   endtask

   task automatic read_val(output logic [15:0] v);
      logic [7:0] h, l;
      bus_read(2'd0, h);
      bus_read(2'd1, l);
      v = {h, l};
   endtask

   function automatic bit edge_ok(input logic [1:0] es, input logic oldp, input logic newp);
      return (es[0] && !oldp && newp) || (es[1] && oldp && !newp);
   endfunction

   function automatic logic exp_pin(input logic [1:0] m, input logic cur);
      return (m == 2'b01) ? ~cur : (m == 2'b10) ? 1'b0 : (m == 2'b11) ? 1'b1 : cur;
   endfunction

   task automatic toggle_and_wait(input logic newp);
      @(negedge clk); cap_pin = newp;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, exp_v;
      logic [7:0]  b;
      logic        pin_e;
      int          c0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R8)
      check(cmp_pin == 0 && cmp_evt == 0 && cap_evt == 0, "R8 reset", {cmp_pin, cmp_evt, cap_evt}, 0);
      pin_e = 1'b0;

      // R2 writes in capture mode, edges off
      bus_write(2'd0, 8'hA5);
      bus_write(2'd1, 8'h3C);
      read_val(v);
      check(v == 16'hA53C, "R2 write both", v, 16'hA53C);
      bus_write(2'd1, 8'h77);
      read_val(v);
      check(v == 16'hA577, "R2 low only", v, 16'hA577);

      // R1 unmapped addresses
      bus_read(2'd2, b);
      check(b == 0, "R1 addr2", b, 0);
      bus_read(2'd3, b);
      check(b == 0, "R1 addr3", b, 0);

      // R4 random captures over edge selections (R3 capture mode = 00)
      exp_v = v;
      for (int i = 0; i < 40; i++) begin
         logic [1:0] es; logic np; bit hit;
         es = 2'($urandom_range(0, 3));
         np = 1'($urandom);
         @(negedge clk); edge_sel = es; cnt_in = 16'($urandom);
         hit = edge_ok(es, cap_pin, np);
         c0 = cap_seen;
         toggle_and_wait(np);
         if (hit) exp_v = cnt_in;
         read_val(v);
         check(v == exp_v, "R4 capture value", v, exp_v);
         check(cap_seen - c0 == (hit ? 1 : 0), "R4 cap_evt count", cap_seen - c0, hit ? 1 : 0);
      end

      // R5 lock: high read blocks captures until low read
      edge_sel = 2'b11;
      @(negedge clk); cnt_in = 16'h1234;
      toggle_and_wait(~cap_pin);
      bus_read(2'd0, b);
      check(b == 8'h12, "R5 hi", b, 8'h12);
      @(negedge clk); cnt_in = 16'hBEEF;
      c0 = cap_seen;
      toggle_and_wait(~cap_pin);
      check(cap_seen == c0, "R5 discarded edge", cap_seen - c0, 0);
      bus_read(2'd1, b);
      check(b == 8'h34, "R5 lo coherent", b, 8'h34);
      read_val(v);
      check(v == 16'h1234, "R5 not queued", v, 16'h1234);
      @(negedge clk); cnt_in = 16'h5A5A;
      toggle_and_wait(~cap_pin);
      read_val(v);
      check(v == 16'h5A5A, "R5 unlocked capture", v, 16'h5A5A);

      // R10 capture coinciding with a write
      @(negedge clk); cnt_in = 16'hC0DE; cap_pin = ~cap_pin;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 2'd1; bus_wdata = 8'h00; bus_wr = 1'b1;
      @(posedge clk); #1 bus_wr = 1'b0;
      repeat (2) @(negedge clk);
      read_val(v);
      check(v == 16'hC0DE, "R10 capture wins", v, 16'hC0DE);

      // R9 capture mode: counter equal gives no compare
      c0 = cmp_seen;
      @(negedge clk); cnt_in = 16'hC0DE;
      repeat (3) @(negedge clk);
      check(cmp_seen == c0 && cmp_pin == pin_e, "R9 no cmp in capture", cmp_seen - c0, 0);

      // R6/R8 random compares
      for (int i = 0; i < 30; i++) begin
         logic [1:0] m; logic [15:0] cv;
         m  = 2'($urandom_range(1, 3));
         cv = 16'($urandom);
         @(negedge clk); cnt_in = ~cv; mode_sel = m;
         bus_write(2'd0, cv[15:8]);
         bus_write(2'd1, cv[7:0]);
         @(negedge clk); cnt_in = cv;
         @(negedge clk);
         pin_e = exp_pin(m, pin_e);
         check(cmp_evt == 1, "R6 compare event", cmp_evt, 1);
         check(cmp_pin == pin_e, "R8 pin action", cmp_pin, pin_e);
         cnt_in = ~cv;
         @(negedge clk);
         check(cmp_evt == 0, "R6 pulse ends", cmp_evt, 0);
      end

      // R6 held equality gives one pulse
      mode_sel = 2'b01;
      c0 = cmp_seen;
      @(negedge clk); cnt_in = 16'h0F0F;
      bus_write(2'd0, 8'h0F);
      bus_write(2'd1, 8'h0F);
      repeat (5) @(negedge clk);
      pin_e = ~pin_e;
      check(cmp_seen - c0 == 1, "R6 single pulse", cmp_seen - c0, 1);
      check(cmp_pin == pin_e, "R8 toggle once", cmp_pin, pin_e);

      // R7 compare lock between high and low writes
      @(negedge clk); cnt_in = 16'h0000;
      c0 = cmp_seen;
      bus_write(2'd0, 8'h44);
      @(negedge clk); cnt_in = 16'h440F;
      repeat (2) @(negedge clk);
      check(cmp_seen == c0, "R7 locked half-write", cmp_seen - c0, 0);
      cnt_in = 16'h0000;
      bus_write(2'd1, 8'h55);
      @(negedge clk); cnt_in = 16'h4455;
      @(negedge clk);
      check(cmp_evt == 1, "R7 active after low", cmp_evt, 1);

      // R9 compare mode ignores pin edges; R3 mode 10 is compare
      mode_sel = 2'b10; edge_sel = 2'b11; cnt_in = 16'h9999;
      c0 = cap_seen;
      toggle_and_wait(~cap_pin);
      check(cap_seen == c0, "R9 no capture in compare", cap_seen - c0, 0);
      read_val(v);
      check(v == 16'h4455, "R3 value kept in compare", v, 16'h4455);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule